// File: doc/BRIEF.md
# Deep Sleep Power Mode Sequencer

This block decides which clocks a processor-style system receives and whether its PLL is powered. It has four power modes: full-on (PLL clock, everything running), active (PLL bypassed, slow clock), sleep (core clock stopped, peripherals running) and deep sleep (core and peripheral clocks stopped, PLL powered down). The block runs from an always-on clock. Software writes a staged control word that holds a power-down bit and a bypass bit. The staged word does nothing by itself. It is applied only when the core raises an idle request while its interrupts are masked. That idle request is the PLL programming handshake.

An idle request made with interrupts enabled puts the block in plain sleep, and any interrupt ends it. Deep sleep ends only on a wake event from the always-on timer domain, or on reset. On that wake the PLL is powered up and a programmable lock count runs down before the clocks return. The system always resumes in active mode, with the core clock taken from the bypass source. To get back to full speed, software clears the bypass bit and issues a second handshake. If the wake event is already pending when deep sleep is requested, the request is refused and flagged, so the system cannot stop with no way back.

Top module: `psm_top`

## Requirements
- R1: Reset, whether taken from a running or a deep-sleep state, gives mode_o = 2'b00 (full-on), both clock enables 1, pll_pd_o 0, pll_byp_o 0, and wake_ack_o and wake_err_o 0. It also clears the staged control word, so a following masked idle request keeps full-on mode.
- R2: Writing the staged control word (cfg_wr_i) has no effect on any output until a masked idle request (idle_req_i with irq_mask_i = 1) is accepted in a running mode.
- R3: A masked idle request with the staged power-down bit set and rtc_wake_i low gives, in the next cycle, mode_o = 2'b11 (deep sleep), core_clk_en_o 0, per_clk_en_o 0, pll_pd_o 1 and no acknowledge. pll_pd_o is 1 only in deep sleep.
- R4: While in deep sleep, idle_req_i and irq_i are ignored. The mode stays 2'b11 and the PLL stays powered down.
- R5: When rtc_wake_i is sampled in deep sleep, pll_pd_o falls in the next cycle. With lock count L = lock_cnt_i, both clocks stay gated for exactly L+1 further cycles. Then mode_o becomes 2'b01 (active), both clocks are enabled, pll_byp_o is 1 and wake_ack_o pulses in that same cycle.
- R6: Entering deep sleep clears the staged power-down bit and sets the staged bypass bit. A masked idle request after the wake, with no new write, therefore keeps active mode and does not sleep again.
- R7: In active mode, writing bypass = 0 and issuing a masked idle request gives mode_o = 2'b00, pll_byp_o 0 and a wake_ack_o pulse in the next cycle.
- R8: In full-on mode, writing bypass = 1 and issuing a masked idle request gives mode_o = 2'b01, pll_byp_o 1 and a wake_ack_o pulse in the next cycle.
- R9: A masked idle request with power-down staged while rtc_wake_i is already high does not enter deep sleep. In the next cycle wake_err_o and wake_ack_o pulse together and the mode is unchanged. The power-down bit stays staged for a retry.
- R10: An idle request with irq_mask_i = 0 gives mode_o = 2'b10 (sleep), core_clk_en_o 0, per_clk_en_o 1 and the PLL controls unchanged, without applying the staged word. irq_i or rtc_wake_i returns the block to its previous running mode, with a wake_ack_o pulse in the next cycle.
- R11: A masked idle request that changes nothing is acknowledged with a wake_ack_o pulse in the next cycle, and the mode is unchanged.
- R12: wake_ack_o and wake_err_o are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Write strobe for the staged control word |
| cfg_pd_i | input | 1 | Staged power-down bit value |
| cfg_byp_i | input | 1 | Staged PLL bypass bit value |
| lock_cnt_i | input | LOCK_W | PLL lock wait count, loaded on wake |
| idle_req_i | input | 1 | Idle request from the core (handshake) |
| irq_mask_i | input | 1 | 1 when core interrupts are masked |
| irq_i | input | 1 | Any interrupt, ends plain sleep |
| rtc_wake_i | input | 1 | Pending wake event from the always-on timer |
| core_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| pll_pd_o | output | 1 | PLL power-down |
| pll_byp_o | output | 1 | Core clock taken from the bypass source |
| mode_o | output | 2 | Mode: 00 full-on, 01 active, 10 sleep, 11 deep sleep |
| wake_ack_o | output | 1 | One-cycle acknowledge of the idle handshake |
| wake_err_o | output | 1 | One-cycle flag: deep sleep refused, wake already pending |

## Verification
A wrong sequencer state shows up at once on mode_o and on the clock enables, which are decoded straight from that state. A staged word applied too early would move pll_byp_o or mode_o before any handshake. A lock counter off by one moves the cycle in which core_clk_en_o comes back, so the bench counts the cycles from the wake to the release, with both a non-zero and a zero lock count. A lost or doubled acknowledge appears on wake_ack_o within one cycle of the handshake. A missing pending-wake check appears as mode_o reaching 11 instead of a wake_err_o pulse.

// File: rtl/psm_pkg.sv
package psm_pkg;

    typedef enum logic [1:0] {
        PM_FULL   = 2'b00,
        PM_ACTIVE = 2'b01,
        PM_SLEEP  = 2'b10,
        PM_DEEP   = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        SQ_RUN,
        SQ_SLEEP,
        SQ_DEEP,
        SQ_LOCK
    } seq_st_e;

    typedef struct packed {
        logic core_en;
        logic per_en;
        logic pll_pd;
        logic pll_byp;
    } clk_ctl_t;

    typedef struct packed {
        logic pd;
        logic byp;
    } ctl_word_t;

    function automatic clk_ctl_t ctl_for(seq_st_e st, logic byp);
        clk_ctl_t c;
        c = '{core_en: 1'b1, per_en: 1'b1, pll_pd: 1'b0, pll_byp: byp};
        case (st)
            SQ_RUN:   c = '{core_en: 1'b1, per_en: 1'b1, pll_pd: 1'b0, pll_byp: byp};
            SQ_SLEEP: c = '{core_en: 1'b0, per_en: 1'b1, pll_pd: 1'b0, pll_byp: byp};
            SQ_DEEP:  c = '{core_en: 1'b0, per_en: 1'b0, pll_pd: 1'b1, pll_byp: 1'b1};
            SQ_LOCK:  c = '{core_en: 1'b0, per_en: 1'b0, pll_pd: 1'b0, pll_byp: 1'b1};
            default:  c = '{core_en: 1'b1, per_en: 1'b1, pll_pd: 1'b0, pll_byp: byp};
        endcase
        return c;
    endfunction

    function automatic pmode_e mode_for(seq_st_e st, logic byp);
        pmode_e m;
        m = PM_FULL;
        case (st)
            SQ_RUN:   m = byp ? PM_ACTIVE : PM_FULL;
            SQ_SLEEP: m = PM_SLEEP;
            SQ_DEEP:  m = PM_DEEP;
            SQ_LOCK:  m = PM_DEEP;
            default:  m = PM_FULL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/psm_ctrl_reg.sv
module psm_ctrl_reg
    import psm_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      wr_i,
    input  ctl_word_t wdata_i,
    input  logic      deep_enter_i,
    output ctl_word_t word_o
);

    ctl_word_t word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '{pd: 1'b0, byp: 1'b0};
        end else if (deep_enter_i) begin
            // entering deep sleep consumes power-down and leaves bypass staged
            word_q <= '{pd: 1'b0, byp: 1'b1};
        end else if (wr_i) begin
            word_q <= wdata_i;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/psm_lock_timer.sv
module psm_lock_timer #(
    parameter int LOCK_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [LOCK_W-1:0] count_i,
    output logic              done_o
);

    localparam logic [LOCK_W-1:0] CNT_ZERO = '0;
    localparam logic [LOCK_W-1:0] CNT_ONE  = LOCK_W'(1);

    logic [LOCK_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= CNT_ZERO;
        end else if (load_i) begin
            cnt_q <= count_i;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign done_o = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/psm_fsm.sv
module psm_fsm
    import psm_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  ctl_word_t staged_i,
    input  logic      idle_req_i,
    input  logic      irq_mask_i,
    input  logic      irq_i,
    input  logic      rtc_wake_i,
    input  logic      lock_done_i,
    output logic      deep_enter_o,
    output logic      lock_load_o,
    output seq_st_e   st_o,
    output logic      byp_o,
    output logic      ack_o,
    output logic      err_o
);

    seq_st_e st_q, st_d;
    logic    byp_q, byp_d;
    logic    ack_q, ack_d;
    logic    err_q, err_d;

    always_comb begin
        st_d         = st_q;
        byp_d        = byp_q;
        ack_d        = 1'b0;
        err_d        = 1'b0;
        deep_enter_o = 1'b0;
        lock_load_o  = 1'b0;
        case (st_q)
            SQ_RUN: begin
                if (idle_req_i) begin
                    if (!irq_mask_i) begin
                        st_d = SQ_SLEEP;
                    end else if (staged_i.pd) begin
                        if (rtc_wake_i) begin
                            // wake already pending: refuse rather than stall
                            err_d = 1'b1;
                            ack_d = 1'b1;
                        end else begin
                            st_d         = SQ_DEEP;
                            deep_enter_o = 1'b1;
                        end
                    end else begin
                        byp_d = staged_i.byp;
                        ack_d = 1'b1;
                    end
                end
            end
            SQ_SLEEP: begin
                if (irq_i || rtc_wake_i) begin
                    st_d  = SQ_RUN;
                    ack_d = 1'b1;
                end
            end
            SQ_DEEP: begin
                if (rtc_wake_i) begin
                    st_d        = SQ_LOCK;
                    lock_load_o = 1'b1;
                end
            end
            SQ_LOCK: begin
                if (lock_done_i) begin
                    st_d  = SQ_RUN;
                    byp_d = 1'b1;
                    ack_d = 1'b1;
                end
            end
            default: st_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= SQ_RUN;
            byp_q <= 1'b0;
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            byp_q <= byp_d;
            ack_q <= ack_d;
            err_q <= err_d;
        end
    end

    assign st_o  = st_q;
    assign byp_o = byp_q;
    assign ack_o = ack_q;
    assign err_o = err_q;

endmodule

// File: rtl/psm_top.sv
module psm_top
    import psm_pkg::*;
#(
    parameter int LOCK_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_pd_i,
    input  logic              cfg_byp_i,
    input  logic [LOCK_W-1:0] lock_cnt_i,
    input  logic              idle_req_i,
    input  logic              irq_mask_i,
    input  logic              irq_i,
    input  logic              rtc_wake_i,
    output logic              core_clk_en_o,
    output logic              per_clk_en_o,
    output logic              pll_pd_o,
    output logic              pll_byp_o,
    output logic [1:0]        mode_o,
    output logic              wake_ack_o,
    output logic              wake_err_o
);

    ctl_word_t wdata;
    ctl_word_t staged;
    logic      deep_enter;
    logic      lock_load;
    logic      lock_done;
    seq_st_e   st;
    logic      app_byp;
    clk_ctl_t  ctl;

    assign wdata = '{pd: cfg_pd_i, byp: cfg_byp_i};

    psm_ctrl_reg u_reg (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .wr_i         (cfg_wr_i),
        .wdata_i      (wdata),
        .deep_enter_i (deep_enter),
        .word_o       (staged)
    );

    psm_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .load_i  (lock_load),
        .count_i (lock_cnt_i),
        .done_o  (lock_done)
    );

    psm_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .staged_i     (staged),
        .idle_req_i   (idle_req_i),
        .irq_mask_i   (irq_mask_i),
        .irq_i        (irq_i),
        .rtc_wake_i   (rtc_wake_i),
        .lock_done_i  (lock_done),
        .deep_enter_o (deep_enter),
        .lock_load_o  (lock_load),
        .st_o         (st),
        .byp_o        (app_byp),
        .ack_o        (wake_ack_o),
        .err_o        (wake_err_o)
    );

    assign ctl           = ctl_for(st, app_byp);
    assign core_clk_en_o = ctl.core_en;
    assign per_clk_en_o  = ctl.per_en;
    assign pll_pd_o      = ctl.pll_pd;
    assign pll_byp_o     = ctl.pll_byp;
    assign mode_o        = mode_for(st, app_byp);

endmodule

// File: rtl/psm_checker.sv
module psm_checker
    import psm_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] mode_o,
    input logic       core_clk_en_o,
    input logic       per_clk_en_o,
    input logic       pll_pd_o,
    input logic       pll_byp_o,
    input logic       wake_ack_o,
    input logic       wake_err_o
);

    AST_RESET_FULL: assert property (@(posedge clk_i)
        rst_i |=> (mode_o == PM_FULL) && !wake_ack_o && !wake_err_o); // R1

    AST_DEEP_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == PM_DEEP) |-> (!core_clk_en_o && !per_clk_en_o)); // R3

    AST_PD_ONLY_DEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        pll_pd_o |-> (mode_o == PM_DEEP)); // R3

    AST_CORE_NEEDS_PLL: assert property (@(posedge clk_i) disable iff (rst_i)
        core_clk_en_o |-> !pll_pd_o); // R5

    AST_WAKE_TO_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(mode_o) == PM_DEEP && mode_o != PM_DEEP)
        |-> (mode_o == PM_ACTIVE && wake_ack_o && pll_byp_o)); // R5

    AST_ERR_HOLDS_MODE: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_err_o |-> (wake_ack_o && mode_o == $past(mode_o))); // R9

    AST_SLEEP_PER_ON: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == PM_SLEEP) |-> (per_clk_en_o && !core_clk_en_o)); // R10

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_ack_o |=> !wake_ack_o); // R12

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_err_o |=> !wake_err_o); // R12

endmodule

bind psm_top psm_checker u_psm_checker (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .mode_o        (mode_o),
    .core_clk_en_o (core_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .pll_pd_o      (pll_pd_o),
    .pll_byp_o     (pll_byp_o),
    .wake_ack_o    (wake_ack_o),
    .wake_err_o    (wake_err_o)
);

// File: tb/test_psm_top.sv
module test_psm_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic              cfg_pd = 1'b0;
    logic              cfg_byp = 1'b0;
    logic [LOCK_W-1:0] lock_cnt = '0;
    logic              idle_req = 1'b0;
    logic              irq_mask = 1'b1;
    logic              irq = 1'b0;
    logic              rtc_wake = 1'b0;
    logic              core_en, per_en, pll_pd, pll_byp, ack, err;
    logic [1:0]        mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psm_top #(.LOCK_W(LOCK_W)) i_psm_top (
        .clk_i         (clk),
        .rst_i         (rst),
        .cfg_wr_i      (cfg_wr),
        .cfg_pd_i      (cfg_pd),
        .cfg_byp_i     (cfg_byp),
        .lock_cnt_i    (lock_cnt),
        .idle_req_i    (idle_req),
        .irq_mask_i    (irq_mask),
        .irq_i         (irq),
        .rtc_wake_i    (rtc_wake),
        .core_clk_en_o (core_en),
        .per_clk_en_o  (per_en),
        .pll_pd_o      (pll_pd),
        .pll_byp_o     (pll_byp),
        .mode_o        (mode),
        .wake_ack_o    (ack),
        .wake_err_o    (err)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // clocks {core,per,pd,byp} packed as 4 bits
    task automatic check_out(string req, int exp_mode, int exp_clk, int exp_ack, int exp_err);
        check(req, "mode", int'(mode), exp_mode);
        check(req, "clocks", int'({core_en, per_en, pll_pd, pll_byp}), exp_clk);
        check(req, "ack", int'(ack), exp_ack);
        check(req, "err", int'(err), exp_err);
    endtask

    task automatic write_cfg(logic pd, logic byp);
        cfg_wr = 1'b1; cfg_pd = pd; cfg_byp = byp;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic handshake(logic mask);
        idle_req = 1'b1; irq_mask = mask;
        @(negedge clk);
        idle_req = 1'b0; irq_mask = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check_out("R1", 0, 4'b1100, 0, 0);
        handshake(1'b1);
        check_out("R1", 0, 4'b1100, 1, 0);
        @(negedge clk);
    endtask

    task automatic t_staged_idle();
        write_cfg(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check_out("R2", 0, 4'b1100, 0, 0);
    endtask

    task automatic t_sleep();
        handshake(1'b0);
        check_out("R10", 2, 4'b0100, 0, 0);
        repeat (2) @(negedge clk);
        check_out("R10", 2, 4'b0100, 0, 0);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check_out("R10", 0, 4'b1100, 1, 0);
        @(negedge clk);
        check("R12", "ack second cycle", int'(ack), 0);
    endtask

    task automatic t_pending_wake();
        rtc_wake = 1'b1;
        handshake(1'b1);
        check_out("R9", 0, 4'b1100, 1, 1);
        rtc_wake = 1'b0;
        @(negedge clk);
        check("R12", "err second cycle", int'(err), 0);
        check("R9", "mode after refusal", int'(mode), 0);
    endtask

    task automatic t_enter_deep();
        handshake(1'b1);
        check_out("R3", 3, 4'b0011, 0, 0);
    endtask

    task automatic t_deep_ignores();
        handshake(1'b1);
        check_out("R4", 3, 4'b0011, 0, 0);
        handshake(1'b0);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check_out("R4", 3, 4'b0011, 0, 0);
    endtask

    task automatic t_wake(int lock);
        int n;
        lock_cnt = LOCK_W'(lock);
        rtc_wake = 1'b1;
        @(negedge clk);
        rtc_wake = 1'b0;
        n = 1;
        check("R5", "pll_pd after wake", int'(pll_pd), 0);
        check("R5", "core gated in lock", int'(core_en), 0);
        check("R5", "mode in lock", int'(mode), 3);
        while (!core_en && n < 300) begin
            @(negedge clk);
            n++;
        end
        check("R5", "release cycle", n, lock + 2);
        check_out("R5", 1, 4'b1101, 1, 0);
        @(negedge clk);
        check("R12", "wake ack second cycle", int'(ack), 0);
    endtask

    task automatic t_after_wake();
        handshake(1'b1);
        check_out("R6", 1, 4'b1101, 1, 0);
        @(negedge clk);
    endtask

    task automatic t_to_full();
        write_cfg(1'b0, 1'b0);
        check("R2", "mode before handshake", int'(mode), 1);
        handshake(1'b1);
        check_out("R7", 0, 4'b1100, 1, 0);
        @(negedge clk);
    endtask

    task automatic t_to_active();
        write_cfg(1'b0, 1'b1);
        handshake(1'b1);
        check_out("R8", 1, 4'b1101, 1, 0);
        @(negedge clk);
        write_cfg(1'b0, 1'b0);
        handshake(1'b1);
        @(negedge clk);
    endtask

    task automatic t_noop();
        handshake(1'b1);
        check_out("R11", 0, 4'b1100, 1, 0);
        @(negedge clk);
        check("R12", "noop ack second cycle", int'(ack), 0);
    endtask

    task automatic t_reset_from_deep();
        write_cfg(1'b1, 1'b0);
        handshake(1'b1);
        check("R3", "deep before reset", int'(mode), 3);
        do_reset();
        check_out("R1", 0, 4'b1100, 0, 0);
        handshake(1'b1);
        check_out("R1", 0, 4'b1100, 1, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_staged_idle();
        t_sleep();
        t_pending_wake();
        t_enter_deep();
        t_deep_ignores();
        t_wake(5);
        t_after_wake();
        t_to_full();
        t_to_active();
        t_noop();
        write_cfg(1'b1, 1'b0);
        t_enter_deep();
        t_wake(0);
        t_to_full();
        t_reset_from_deep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule